// File: doc/BRIEF.md
# Dual-CPU Address Region Decoder

This block sits between two processors and the shared address space. For the main CPU it takes a 24-bit address with read and write strobes and names the region that the access falls in: cartridge space, an illegal area that must stall the bus, the I/O and control registers, the video ports, the window into the sub-CPU's space, or work RAM. The top byte of the address picks a 64 KB slot, and the slot picks the region. For the sub-CPU it takes a 16-bit address with a request strobe and says whether the access lands in the sub-CPU's small local RAM, giving the RAM word address.

A mode input selects an alternate map. In that map one low slot of the illegal range becomes a read-only register area, and the I/O slot becomes an idle-bus area: reads there return the idle bus value and writes are dropped. A write that must be dropped raises a flag for the bus logic. All outputs are registered and appear on the clock edge after the inputs are sampled.

Top module: `dual_cpu_region_decode`

## Requirements
- R1: A main access (read or write strobe) with address bit 23 clear raises `main_sel[0]` (cartridge) one clock later.
- R2: A main access to a slot from 0x80 to 0xDF that no other requirement claims raises `main_sel[1]` and `lockup` one clock later, in both modes.
- R3: A main access to slot 0xA0 raises `main_sel[4]` (sub-CPU window) in both modes.
- R4: With `alt_map` low, a main access to slot 0xA1 raises `main_sel[2]` (I/O and control).
- R5: A main access to slot 0xC0, 0xC8, 0xD0 or 0xD8 raises `main_sel[3]` (video); other slots between 0xC0 and 0xDF are illegal.
- R6: A main access to any slot from 0xE0 to 0xFF raises `main_sel[5]` (work RAM) and sets `wram_addr` to address bits 15:0, so all those slots mirror one 64 KB RAM.
- R7: With `alt_map` high, slot 0x80 raises `main_sel[6]` (extra registers); a write there also raises `wr_drop`.
- R8: With `alt_map` high, slot 0xA1 raises `main_sel[7]` (idle bus); a write there also raises `wr_drop`.
- R9: Exactly one bit of `main_sel` is high the clock after any main access, none after a clock without one; `wr_drop` is high only after a write to an R7 or R8 area and `lockup` only with `main_sel[1]`.
- R10: A sub access (`sub_req`) to addresses 0x0000 to 0x3FFF raises `sub_ram_sel` one clock later with `sub_ram_addr` equal to address bits 12:0 (8 KB mirrored twice); any other sub address, or no request, leaves `sub_ram_sel` low.
- R11: While reset is held, every select, `lockup` and `wr_drop` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_addr | input | 24 | Main CPU address |
| main_rd | input | 1 | Main CPU read strobe |
| main_wr | input | 1 | Main CPU write strobe |
| alt_map | input | 1 | Selects the alternate map |
| sub_addr | input | 16 | Sub CPU address |
| sub_req | input | 1 | Sub CPU access strobe |
| main_sel | output | 8 | One-hot main region select |
| lockup | output | 1 | Access hit the illegal area |
| wr_drop | output | 1 | Write to a read-only or idle area is to be ignored |
| wram_addr | output | 16 | Work RAM address, mirrored |
| sub_ram_sel | output | 1 | Sub access hits local RAM |
| sub_ram_addr | output | 13 | Local RAM address, mirrored |

## Verification
The assertions assume the main read and write strobes are never high in the same clock and that the address and mode are steady for the cycle the strobe is sampled. The stimulus drives exactly one strobe per access on the falling edge, inserts idle cycles between accesses, and sweeps every slot from 0x80 to 0xFF in both modes for reads and writes, plus cartridge corners and sub addresses on both sides of the 16 KB window and the 8 KB mirror point.

// File: rtl/region_pkg.sv
package region_pkg;

  localparam int SLOT_W = 8;

  typedef enum logic [2:0] {
    RG_CART   = 3'd0,
    RG_TRAP   = 3'd1,
    RG_IO     = 3'd2,
    RG_VIDEO  = 3'd3,
    RG_SUBWIN = 3'd4,
    RG_WRAM   = 3'd5,
    RG_EXTRA  = 3'd6,
    RG_IDLE   = 3'd7
  } region_e;

  localparam int NUM_REGIONS = 8;

  localparam logic [SLOT_W-1:0] SLOT_EXTRA     = 8'h80;
  localparam logic [SLOT_W-1:0] SLOT_SUBWIN    = 8'hA0;
  localparam logic [SLOT_W-1:0] SLOT_IO        = 8'hA1;
  localparam logic [SLOT_W-1:0] SLOT_VID_FIRST = 8'hC0;
  localparam logic [SLOT_W-1:0] SLOT_WRAM_LO   = 8'hE0;
  localparam int                VID_STRIDE_LG  = 3;

endpackage

// File: rtl/reset_sync.sv
module reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/slot_classifier.sv
module slot_classifier
  import region_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  input  logic              alt_map,
  output region_e           region,
  output logic              wr_ignored
);

  logic is_video;

  always_comb begin
    is_video = (slot >= SLOT_VID_FIRST) && (slot < SLOT_WRAM_LO) &&
               (slot[VID_STRIDE_LG-1:0] == '0);
  end

  always_comb begin
    region     = RG_TRAP;
    wr_ignored = 1'b0;
    if (!slot[SLOT_W-1]) begin
      region = RG_CART;
    end else if (slot >= SLOT_WRAM_LO) begin
      region = RG_WRAM;
    end else if (slot == SLOT_SUBWIN) begin
      region = RG_SUBWIN;
    end else if (slot == SLOT_IO) begin
      if (alt_map) begin
        region     = RG_IDLE;
        wr_ignored = 1'b1;
      end else begin
        region = RG_IO;
      end
    end else if (alt_map && slot == SLOT_EXTRA) begin
      region     = RG_EXTRA;
      wr_ignored = 1'b1;
    end else if (is_video) begin
      region = RG_VIDEO;
    end
  end

endmodule

// File: rtl/main_region_stage.sv
module main_region_stage
  import region_pkg::*;
#(
  parameter int AW      = 24,
  parameter int WRAM_AW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          addr,
  input  logic                   rd,
  input  logic                   wr,
  input  logic                   alt_map,
  output logic [NUM_REGIONS-1:0] sel,
  output logic                   lockup,
  output logic                   wr_drop,
  output logic [WRAM_AW-1:0]     wram_addr
);

  localparam int SLOT_LSB = AW - SLOT_W;

  logic [SLOT_W-1:0]      slot;
  region_e                region;
  logic                   wr_ignored;
  logic                   strobe;

  logic [NUM_REGIONS-1:0] sel_d, sel_q;
  logic                   lockup_d, lockup_q;
  logic                   drop_d, drop_q;
  logic [WRAM_AW-1:0]     wram_d, wram_q;

  assign slot   = addr[AW-1:SLOT_LSB];
  assign strobe = rd | wr;

  slot_classifier u_cls (
    .slot       (slot),
    .alt_map    (alt_map),
    .region     (region),
    .wr_ignored (wr_ignored)
  );

  for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_sel
    assign sel_d[gi] = strobe && (region == region_e'(gi));
  end

  always_comb begin
    lockup_d = strobe && (region == RG_TRAP);
    drop_d   = wr && wr_ignored;
    wram_d   = wram_q;
    if (strobe) wram_d = addr[WRAM_AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      lockup_q <= 1'b0;
      drop_q   <= 1'b0;
      wram_q   <= '0;
    end else begin
      sel_q    <= sel_d;
      lockup_q <= lockup_d;
      drop_q   <= drop_d;
      wram_q   <= wram_d;
    end
  end

  assign sel       = sel_q;
  assign lockup    = lockup_q;
  assign wr_drop   = drop_q;
  assign wram_addr = wram_q;

  AST_CART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !addr[AW-1]) |=> sel[RG_CART]); // R1
  AST_LOCK_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |-> sel[RG_TRAP]); // R2
  AST_WRAM_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && slot >= SLOT_WRAM_LO) |=>
      (sel[RG_WRAM] && wram_addr == $past(addr[WRAM_AW-1:0]))); // R6
  AST_ALT_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && alt_map && (slot == SLOT_IO || slot == SLOT_EXTRA)) |=> wr_drop); // R8
  AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> ($countones(sel) == 1)); // R9
  AST_NO_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> (sel == '0 && !lockup && !wr_drop)); // R9
  AST_READ_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !wr_drop); // R9

endmodule

// File: rtl/sub_ram_stage.sv
module sub_ram_stage #(
  parameter int SUB_AW = 16,
  parameter int WIN_AW = 14,
  parameter int RAM_AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SUB_AW-1:0] addr,
  input  logic              req,
  output logic              ram_sel,
  output logic [RAM_AW-1:0] ram_addr
);

  logic              hit;
  logic              sel_d, sel_q;
  logic [RAM_AW-1:0] addr_d, addr_q;

  always_comb begin
    hit    = req && (addr[SUB_AW-1:WIN_AW] == '0);
    sel_d  = hit;
    addr_d = addr_q;
    if (hit) addr_d = addr[RAM_AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      sel_q  <= sel_d;
      addr_q <= addr_d;
    end
  end

  assign ram_sel  = sel_q;
  assign ram_addr = addr_q;

  AST_SUB_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && addr[SUB_AW-1:WIN_AW] == '0) |=>
      (ram_sel && ram_addr == $past(addr[RAM_AW-1:0]))); // R10
  AST_SUB_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (!req || addr[SUB_AW-1:WIN_AW] != '0) |=> !ram_sel); // R10

endmodule

// File: rtl/dual_cpu_region_decode.sv
module dual_cpu_region_decode
  import region_pkg::*;
#(
  parameter int MAIN_AW    = 24,
  parameter int WRAM_AW    = 16,
  parameter int SUB_AW     = 16,
  parameter int SUB_WIN_AW = 14,
  parameter int SUB_RAM_AW = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [MAIN_AW-1:0]     main_addr,
  input  logic                   main_rd,
  input  logic                   main_wr,
  input  logic                   alt_map,
  input  logic [SUB_AW-1:0]      sub_addr,
  input  logic                   sub_req,
  output logic [NUM_REGIONS-1:0] main_sel,
  output logic                   lockup,
  output logic                   wr_drop,
  output logic [WRAM_AW-1:0]     wram_addr,
  output logic                   sub_ram_sel,
  output logic [SUB_RAM_AW-1:0]  sub_ram_addr
);

  logic rst_n_sync;

  reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  main_region_stage #(
    .AW      (MAIN_AW),
    .WRAM_AW (WRAM_AW)
  ) u_main (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .addr      (main_addr),
    .rd        (main_rd),
    .wr        (main_wr),
    .alt_map   (alt_map),
    .sel       (main_sel),
    .lockup    (lockup),
    .wr_drop   (wr_drop),
    .wram_addr (wram_addr)
  );

  sub_ram_stage #(
    .SUB_AW (SUB_AW),
    .WIN_AW (SUB_WIN_AW),
    .RAM_AW (SUB_RAM_AW)
  ) u_sub (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .addr     (sub_addr),
    .req      (sub_req),
    .ram_sel  (sub_ram_sel),
    .ram_addr (sub_ram_addr)
  );

  always_comb begin
    AST_RESET_QUIET: assert (rst_n_sync || (main_sel == '0 && !lockup && !wr_drop && !sub_ram_sel)); // R11
  end

endmodule

// File: tb/dual_cpu_region_decode_test.sv
module dual_cpu_region_decode_test;

  logic        clk;
  logic        rst_n;
  logic [23:0] main_addr;
  logic        main_rd;
  logic        main_wr;
  logic        alt_map;
  logic [15:0] sub_addr;
  logic        sub_req;
  logic [7:0]  main_sel;
  logic        lockup;
  logic        wr_drop;
  logic [15:0] wram_addr;
  logic        sub_ram_sel;
  logic [12:0] sub_ram_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  dual_cpu_region_decode uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .main_addr    (main_addr),
    .main_rd      (main_rd),
    .main_wr      (main_wr),
    .alt_map      (alt_map),
    .sub_addr     (sub_addr),
    .sub_req      (sub_req),
    .main_sel     (main_sel),
    .lockup       (lockup),
    .wr_drop      (wr_drop),
    .wram_addr    (wram_addr),
    .sub_ram_sel  (sub_ram_sel),
    .sub_ram_addr (sub_ram_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference: region number for an address, by plain ranges.
  function automatic int ref_region(int a, bit alt);
    int s;
    s = a / 65536;
    if (a < 'h800000) return 0;
    if (s >= 'hE0) return 5;
    if (s == 'hA0) return 4;
    if (s == 'hA1) return alt ? 7 : 2;
    if (alt && s == 'h80) return 6;
    if (s == 'hC0 || s == 'hC8 || s == 'hD0 || s == 'hD8) return 3;
    return 1;
  endfunction

  function automatic string region_tag(int r);
    case (r)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R3";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Apply one cycle of inputs at a falling edge, then compare at the next one.
  task automatic step(int ma, bit rd, bit wr, bit alt, int sa, bit sreq);
    int  r;
    bit  strobe;
    int  exp_sel;
    bit  exp_drop;
    bit  exp_sub;
    main_addr = 24'(ma);
    main_rd   = rd;
    main_wr   = wr;
    alt_map   = alt;
    sub_addr  = 16'(sa);
    sub_req   = sreq;
    @(negedge clk);
    strobe   = rd | wr;
    r        = ref_region(ma, alt);
    exp_sel  = strobe ? (1 << r) : 0;
    exp_drop = wr && (r == 6 || r == 7);
    exp_sub  = sreq && (sa < 'h4000);
    check(main_sel == 8'(exp_sel), strobe ? region_tag(r) : "R9",
          "main_sel", int'(main_sel), exp_sel);
    check(lockup == (strobe && r == 1), "R2", "lockup", int'(lockup), int'(strobe && r == 1));
    check(wr_drop == exp_drop, (r == 6) ? "R7" : ((r == 7) ? "R8" : "R9"),
          "wr_drop", int'(wr_drop), int'(exp_drop));
    if (strobe && r == 5)
      check(wram_addr == 16'(ma % 65536), "R6", "wram_addr", int'(wram_addr), ma % 65536);
    check(sub_ram_sel == exp_sub, "R10", "sub_ram_sel", int'(sub_ram_sel), int'(exp_sub));
    if (exp_sub)
      check(sub_ram_addr == 13'(sa % 8192), "R10", "sub_ram_addr", int'(sub_ram_addr), sa % 8192);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; main_addr = '0; main_rd = 1'b1; main_wr = 1'b0;
    alt_map = 1'b0; sub_addr = '0; sub_req = 1'b1;
    repeat (3) @(negedge clk);
    // R11: outputs quiet while reset held, even with strobes active
    check(main_sel == 8'h00 && !lockup && !wr_drop && !sub_ram_sel, "R11",
          "reset outputs", int'({main_sel, lockup, wr_drop, sub_ram_sel}), 0);
    main_rd = 1'b0; sub_req = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: cartridge corners
    step('h000000, 1, 0, 0, 'h0000, 1);
    step('h3A5C21, 0, 1, 0, 'h1FFF, 1);
    step('h7FFFFF, 1, 0, 1, 'h2000, 1);
    step('h7FFFFF, 0, 0, 0, 'h2ABC, 1);   // R9 idle cycle
    step('h800000, 1, 0, 0, 'h3FFF, 1);   // R2 first illegal slot
    step('h800000, 0, 0, 0, 'h4000, 1);   // R10 just outside window
    step('hFFFFFF, 0, 1, 1, 'hFFFF, 1);   // R6 top of map
    step('h000000, 0, 0, 0, 'h0100, 0);   // R10 no request

    // Sweep every upper slot in both modes, reads and writes (R2..R9)
    for (int m = 0; m < 2; m++) begin
      for (int s = 'h80; s < 256; s++) begin
        step(s * 65536 + ((s * 'h123) % 65536), 1, 0, bit'(m), (s * 97) % 65536, 1);
        step(s * 65536 + ((s * 'h321) % 65536), 0, 1, bit'(m), (s * 211) % 65536, bit'(s % 2));
        if (s % 16 == 0) step(s * 65536, 0, 0, bit'(m), 0, 0);
      end
    end

    // R10: mirror of the 8 KB RAM within the 16 KB window
    for (int a = 0; a < 'h10000; a += 'h0F1D) step('h100000, 0, 0, 0, a, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule